// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

This block is an eight-pin general-purpose I/O port in which each pin can be claimed by an on-chip serial peripheral. The upper four pins can be claimed by the SPI controller for select, clock, MOSI and MISO. Pins 3:2 can be claimed by a second UART, and pins 1:0 by a first UART. Software sees two byte registers on a plain register bus: an output latch and a direction mask. Each peripheral has an enable input, plus per-pin output and output-enable signals. When a peripheral's enable is high, it takes over the pins of its group.

A data read is direction-aware. Bits whose direction is output return the latch, and bits whose direction is input return the pin level after a two-flop synchronizer. A data write always lands in the latch, but the latch only reaches pins that are configured as outputs and are not owned by a peripheral. The synchronized pin levels are also routed back to the owning peripheral. The register bus is control traffic, not a stream: a write is a single-cycle strobe that is always accepted, so there is no back-pressure. Read data is combinational from the address.

Top module: `pinmux_port8`

## Requirements
- R1: While reset is low, the latch and the direction mask are both zero. With no peripheral enabled, every pin output-enable is therefore low.
- R2: A write strobe at the data address (BASE_ADDR) stores the write data into the latch on that clock edge. This happens whatever the direction and ownership, so a value written while a peripheral owns a pin appears on that pin once ownership is released.
- R3: Reading the data address returns, per bit, the latch when the direction bit is 1 (output) and the synchronized pin level when it is 0 (input).
- R4: A write strobe at the direction address (BASE_ADDR+1) stores the direction mask. Reading that address returns the mask.
- R5: On a pin not owned by a peripheral, pin_out equals the latch bit and pin_oe equals the direction bit.
- R6: While spi_en is 1, pins 7:4 take pin_out and pin_oe from periph_out[7:4] and periph_oe[7:4]. Latch and direction writes do not change these pins.
- R7: While uart_b_en is 1, pins 3:2 take pin_out and pin_oe from periph_out[3:2] and periph_oe[3:2].
- R8: While uart_a_en is 1, pins 1:0 take pin_out and pin_oe from periph_out[1:0] and periph_oe[1:0].
- R9: Each periph_in bit carries the synchronized pin level while its pin is owned, and 0 otherwise.
- R10: A change on pin_in becomes visible to reads and to periph_in after exactly two rising clock edges.
- R11: A write at any other address changes neither register. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| spi_en | input | 1 | SPI claims pins 7:4 |
| uart_b_en | input | 1 | Second UART claims pins 3:2 |
| uart_a_en | input | 1 | First UART claims pins 1:0 |
| periph_out | input | 8 | Peripheral output value per pin |
| periph_oe | input | 8 | Peripheral output enable per pin |
| periph_in | output | 8 | Synchronized pin level to the owning peripheral |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The assertions check several rules on every cycle: the ownership mux for each peripheral group, the GPIO path on free pins, register stores after write strobes, immunity to stray addresses, and the per-bit read-back rule against the pin value from two cycles earlier. Some behaviour can only be shown by the bench scenarios. These are the exact edge at which a pin change becomes visible, and a latch value written while the SPI owns its pins appearing once the SPI releases them. The bench's behavioural model covers a random mix of writes, enables and pin activity on every clock.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  typedef enum logic [1:0] {
    OWN_GPIO   = 2'd0,
    OWN_SPI    = 2'd1,
    OWN_UART_B = 2'd2,
    OWN_UART_A = 2'd3
  } owner_e;

  // Which peripheral may claim a given pin index; the pin order is fixed.
  function automatic owner_e owner_of(input int idx);
    if (idx >= 4 && idx <= 7)      return OWN_SPI;
    else if (idx == 3 || idx == 2) return OWN_UART_B;
    else if (idx == 1 || idx == 0) return OWN_UART_A;
    else                           return OWN_GPIO;
  endfunction
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_regs.sv
module pm_regs #(
  parameter int              W         = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      lvl_sync,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      lat_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] DIR_ADDR  = BASE_ADDR + ADDR_W'(1);

  logic hit_data, hit_dir;
  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_dir  = (bus_addr == DIR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else if (bus_wr) begin
      if (hit_data) lat_q <= bus_wdata;
      if (hit_dir)  dir_q <= bus_wdata;
    end
  end

  // Output bits read back the latch, input bits read the synchronized pad.
  always_comb begin
    bus_rdata = '0;
    if (hit_data)     bus_rdata = (lat_q & dir_q) | (lvl_sync & ~dir_q);
    else if (hit_dir) bus_rdata = dir_q;
  end
endmodule

// File: rtl/pm_pin_slice.sv
module pm_pin_slice
  import pinmux_pkg::*;
#(
  parameter owner_e OWNER = OWN_GPIO
) (
  input  logic spi_en,
  input  logic uart_b_en,
  input  logic uart_a_en,
  input  logic lat_bit,
  input  logic dir_bit,
  input  logic p_out,
  input  logic p_oe,
  input  logic lvl,
  output logic pin_out,
  output logic pin_oe,
  output logic p_in
);
  logic taken;

  if (OWNER == OWN_SPI) begin : g_spi
    assign taken = spi_en;
  end else if (OWNER == OWN_UART_B) begin : g_ub
    assign taken = uart_b_en;
  end else if (OWNER == OWN_UART_A) begin : g_ua
    assign taken = uart_a_en;
  end else begin : g_none
    assign taken = 1'b0;
  end

  assign pin_out = taken ? p_out : lat_bit;
  assign pin_oe  = taken ? p_oe  : dir_bit;
  assign p_in    = taken & lvl;
endmodule

// File: rtl/pinmux_port8.sv
module pinmux_port8
  import pinmux_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h40,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              spi_en,
  input  logic              uart_b_en,
  input  logic              uart_a_en,
  input  logic [7:0]        periph_out,
  input  logic [7:0]        periph_oe,
  output logic [7:0]        periph_in,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe
);
  localparam int W = 8;

  logic [W-1:0] lvl_sync;
  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;

  pm_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  pm_regs #(.W(W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .lvl_sync  (lvl_sync),
    .bus_rdata (bus_rdata),
    .lat_q     (lat_q),
    .dir_q     (dir_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    pm_pin_slice #(.OWNER(owner_of(i))) u_slice (
      .spi_en    (spi_en),
      .uart_b_en (uart_b_en),
      .uart_a_en (uart_a_en),
      .lat_bit   (lat_q[i]),
      .dir_bit   (dir_q[i]),
      .p_out     (periph_out[i]),
      .p_oe      (periph_oe[i]),
      .lvl       (lvl_sync[i]),
      .pin_out   (pin_out[i]),
      .pin_oe    (pin_oe[i]),
      .p_in      (periph_in[i])
    );
  end
endmodule

// File: rtl/pinmux_port8_chk.sv
module pinmux_port8_chk #(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              spi_en,
  input logic              uart_b_en,
  input logic              uart_a_en,
  input logic [7:0]        periph_out,
  input logic [7:0]        periph_oe,
  input logic [7:0]        periph_in,
  input logic [7:0]        pin_in,
  input logic [7:0]        pin_out,
  input logic [7:0]        pin_oe,
  input logic [7:0]        lat_q,
  input logic [7:0]        dir_q
);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_DIR  = BASE_ADDR + ADDR_W'(1);

  // Edges since reset release, saturating; pin history is valid from 2.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (lat_q == 8'h00 && dir_q == 8'h00));

  a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=> lat_q == $past(bus_wdata));

  a_r4_dir_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (dir_q == $past(bus_wdata)));

  a_r11_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != A_DATA && bus_addr != A_DIR) |=> ($stable(lat_q) && $stable(dir_q)));

  a_r11_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_DATA && bus_addr != A_DIR) |-> bus_rdata == 8'h00);

  a_r5_free_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> (pin_out[7:4] == lat_q[7:4] && pin_oe[7:4] == dir_q[7:4]));

  a_r5_free_lower: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_a_en |-> (pin_out[1:0] == lat_q[1:0] && pin_oe[1:0] == dir_q[1:0]));

  a_r6_spi_owns: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pin_out[7:4] == periph_out[7:4] && pin_oe[7:4] == periph_oe[7:4]));

  a_r7_uart_b_owns: assert property (@(posedge clk) disable iff (!rst_n)
    uart_b_en |-> (pin_out[3:2] == periph_out[3:2] && pin_oe[3:2] == periph_oe[3:2]));

  a_r8_uart_a_owns: assert property (@(posedge clk) disable iff (!rst_n)
    uart_a_en |-> (pin_out[1:0] == periph_out[1:0] && pin_oe[1:0] == periph_oe[1:0]));

  a_r3_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && bus_addr == A_DATA) |->
      (((bus_rdata & ~dir_q) == ($past(pin_in, 2) & ~dir_q)) &&
       ((bus_rdata & dir_q) == (lat_q & dir_q))));

  a_r9_spi_in: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && spi_en) |-> ((periph_in & 8'hF0) == ($past(pin_in, 2) & 8'hF0)));

  a_r9_idle_in: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> periph_in[7:4] == 4'h0);
endmodule

bind pinmux_port8 pinmux_port8_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .spi_en     (spi_en),
  .uart_b_en  (uart_b_en),
  .uart_a_en  (uart_a_en),
  .periph_out (periph_out),
  .periph_oe  (periph_oe),
  .periph_in  (periph_in),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .lat_q      (lat_q),
  .dir_q      (dir_q)
);

// File: tb/pinmux_port8_bench.sv
module pinmux_port8_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h40;
  localparam logic [7:0] A_DIR  = 8'h41;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_en = 1'b0, uart_b_en = 1'b0, uart_a_en = 1'b0;
  logic [7:0] periph_out = 8'h00, periph_oe = 8'h00;
  logic [7:0] periph_in;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_port8 u_pinmux_port8 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .uart_b_en(uart_b_en), .uart_a_en(uart_a_en), .periph_out(periph_out),
    .periph_oe(periph_oe), .periph_in(periph_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference: registers plus a queue of sampled pin values.
  int   m_lat = 0, m_dir = 0;
  int   pin_hist[$] = '{0, 0};

  function automatic bit owned(input int b);
    if (b >= 4) return spi_en;
    if (b >= 2) return uart_b_en;
    return uart_a_en;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 0; m_dir = 0;
      pin_hist = '{0, 0};
    end else begin
      if (bus_wr && bus_addr == A_DATA) m_lat = bus_wdata;
      if (bus_wr && bus_addr == A_DIR)  m_dir = bus_wdata;
      pin_hist.push_back(pin_in);
      void'(pin_hist.pop_front());
    end
    cmp_on = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int lvl, e_rd, e_po, e_oe, e_pi;
      lvl = pin_hist[0];
      e_po = 0; e_oe = 0; e_pi = 0;
      for (int b = 0; b < 8; b++) begin
        if (owned(b)) begin
          e_po += periph_out[b] * (1 << b);
          e_oe += periph_oe[b] * (1 << b);
          e_pi += ((lvl >> b) & 1) * (1 << b);
        end else begin
          e_po += ((m_lat >> b) & 1) * (1 << b);
          e_oe += ((m_dir >> b) & 1) * (1 << b);
        end
      end
      if (bus_addr == A_DATA)     e_rd = (m_lat & m_dir) | (lvl & ~m_dir & 8'hFF);
      else if (bus_addr == A_DIR) e_rd = m_dir;
      else                        e_rd = 0;
      chk("R3/R4/R10/R11 model rdata", bus_rdata, e_rd);
      chk("R5/R6/R7/R8 model pin_out", pin_out, e_po);
      chk("R5/R6/R7/R8 model pin_oe", pin_oe, e_oe);
      chk("R9 model periph_in", periph_in, e_pi);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R1 pin_oe in reset", pin_oe, 8'h00);
    chk("R1 pin_out in reset", pin_out, 8'h00);
    step();
    rst_n = 1'b1;
    bus_addr = A_DIR; step(); @(negedge clk);
    chk("R1 dir after reset", bus_rdata, 8'h00);

    // GPIO mix of inputs and outputs
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'h5A);
    pin_in = 8'hC3;
    bus_addr = A_DATA;
    repeat (3) step(); @(negedge clk);
    chk("R3 mixed readback", bus_rdata, 8'hCA);
    chk("R5 pin_out latch", pin_out, 8'h5A);
    chk("R5 pin_oe dir", pin_oe, 8'h0F);
    bus_addr = A_DIR; @(negedge clk);
    chk("R4 dir readback", bus_rdata, 8'h0F);

    // Two-edge synchronizer latency
    bus_addr = A_DATA;
    step(); pin_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    chk("R10 one edge still old", bus_rdata, 8'hCA);
    @(negedge clk);
    chk("R10 two edges new", bus_rdata, 8'h3A);

    // SPI takes the upper pins
    step();
    periph_out = 8'hA0; periph_oe = 8'h60; spi_en = 1'b1;
    step(); @(negedge clk);
    chk("R6 spi pin_out", pin_out, 8'hAA);
    chk("R6 spi pin_oe", pin_oe, 8'h6F);
    chk("R9 spi periph_in", periph_in, 8'h30);
    wr(A_DATA, 8'hFF);
    wr(A_DIR, 8'hFF);
    @(negedge clk);
    chk("R6 latch write blocked", pin_out, 8'hAF);
    chk("R6 dir write blocked", pin_oe, 8'h6F);
    spi_en = 1'b0;
    step(); @(negedge clk);
    chk("R2 latch shows after release", pin_out, 8'hFF);
    chk("R9 periph_in idle", periph_in, 8'h00);

    // UART groups
    periph_out = 8'h08; periph_oe = 8'h04; uart_b_en = 1'b1;
    step(); @(negedge clk);
    chk("R7 uart b pin_out", pin_out, 8'hFB);
    chk("R7 uart b pin_oe", pin_oe, 8'hF7);
    uart_b_en = 1'b0; periph_out = 8'h01; periph_oe = 8'h02; uart_a_en = 1'b1;
    step(); @(negedge clk);
    chk("R8 uart a pin_out", pin_out, 8'hFD);
    chk("R8 uart a pin_oe", pin_oe, 8'hFE);
    uart_a_en = 1'b0;

    // Stray address
    wr(8'h45, 8'h00);
    bus_addr = 8'h45; @(negedge clk);
    chk("R11 stray read zero", bus_rdata, 8'h00);
    bus_addr = A_DATA; @(negedge clk);
    chk("R11 latch untouched", bus_rdata, 8'hFF);

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 7);
      bus_addr  = (r < 3) ? A_DATA : (r < 6) ? A_DIR : 8'(8'h42 + r);
      bus_wr    = $urandom_range(0, 1);
      bus_wdata = 8'($urandom);
      pin_in    = 8'($urandom);
      periph_out = 8'($urandom);
      periph_oe  = 8'($urandom);
      spi_en    = $urandom_range(0, 1);
      uart_b_en = $urandom_range(0, 1);
      uart_a_en = $urandom_range(0, 1);
      step();
    end
    bus_wr = 1'b0;
    step(); @(negedge clk);
    finish_run();
  end
endmodule